// File: doc/BRIEF.md
# Memory-Mapped and Indexed PCI Configuration Access Translator

This block turns CPU loads and stores into PCI configuration cycles. It offers two routes. In the first, the CPU touches a 4 MB memory window, and the address itself names the target. Eleven address bits act as one-hot device selects, and a priority scan turns them into a device number. The low eleven bits carry the function, the register and the byte lane. In the second, the CPU writes a 32-bit index register in I/O space. It then reads or writes an I/O data port, and the cycle targets whatever the index points at. Both routes feed one cycle generator.

The cycle generator drives a single request to a simple configuration responder. The request carries bus, device, function, register, byte enables, direction and lane-aligned write data. The request is held until the responder acknowledges. The responder also reports whether a device was present. The CPU side keeps one request open, held valid until a one-cycle ready pulse. The ready pulse returns right-aligned read data and an error flag. Data is little-endian, and accesses are 1, 2 or 4 bytes wide.

Top module: `cfg_xlate`

## Requirements
- R1: After reset, cpu_ready and cfg_valid are low and the index register reads 0x0000_0000.
- R2: A memory-space access (cpu_io=0) with address in 0x8080_0000..0x80BF_FFFF starts a configuration cycle on bus 0. A memory access outside that range completes with cpu_err=1 and starts no cycle.
- R3: In the window, the device number is the index (0..10) of the lowest set bit among address bits 21:11, so bit 11 gives device 0. When none of those bits is set, the device number is 11.
- R4: In the window, the function is address bits 10:8 and the register number is address bits 7:2.
- R5: cpu_size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The byte enables are the size's low-byte mask (0001, 0011, 1111) shifted left by address bits 1:0. An access whose bytes cross a 4-byte boundary, or that uses size code 3, completes with cpu_err=1 and starts no cycle.
- R6: Write data sits in the low bytes of cpu_wdata and is moved to byte lane addr[1:0] on cfg_wdata. Read data is taken from lane addr[1:0] of cfg_rdata and returned right-aligned, with bytes above the access width zero.
- R7: A read whose cycle is acknowledged with cfg_present=0 returns all-ones in the accessed width: 0xFF, 0xFFFF or 0xFFFF_FFFF.
- R8: The index register sits at I/O address 0x0CF8 and takes only aligned 4-byte accesses; other sizes complete with cpu_err=1. It keeps bits 31 and 23:2, and the other bits read as zero.
- R9: I/O addresses 0x0CFC..0x0CFF form the data port. When index bit 31 is set, an access there starts a cycle with bus = index[23:16], device = index[15:11], function = index[10:8] and register = index[7:2]. Byte enables and lanes follow R5 and R6.
- R10: When index bit 31 is clear, a data-port read returns all-ones in the accessed width and a data-port write is dropped. Neither starts a cycle.
- R11: Only one cycle is open at a time. cfg_valid and its fields stay stable until cfg_ack. cpu_ready pulses for one cycle, in the cycle after the acknowledge.
- R12: Any other I/O address completes with cpu_err=1 and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request, held until cpu_ready |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size code |
| cpu_we | input | 1 | 1 = write |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-aligned read data, valid with cpu_ready |
| cpu_err | output | 1 | Request rejected, valid with cpu_ready |
| cfg_valid | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Cycle is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Responder completes the cycle |
| cfg_rdata | input | 32 | Lane-aligned read data with cfg_ack |
| cfg_present | input | 1 | A device answered, valid with cfg_ack |

## Verification
Some requests finish without a cycle: errors, index accesses and a disabled data port. For these, cpu_ready rises after the first clock edge that sees the request. A request that starts a cycle raises cfg_valid after that first edge. It then raises cpu_ready one edge after the edge that samples cfg_ack. The bench responder acknowledges after a set number of cfg_valid cycles, so the latency it expects is that number plus two edges. Every access counts the edges up to the ready pulse, sampling between edges, and compares that count with the expected latency. The bench also counts completed cycles to show that a rejected or dropped access starts none.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ACT_ERR   = 2'd0,
    ACT_CYCLE = 2'd1,
    ACT_INDEX = 2'd2,
    ACT_DUMMY = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regn;
    logic [3:0] be;
    logic [1:0] lane;
  } cyc_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_B1:   size_bytes = 3'd1;
      SZ_B2:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B1:   size_mask = 32'h0000_00FF;
      SZ_B2:   size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_AW   = 22,
  parameter int          SEL_LO   = 11,
  parameter int          SEL_N    = 11,
  parameter int          IO_AW    = 16,
  parameter logic [15:0] IDX_OFS  = 16'h0CF8,
  parameter logic [15:0] DAT_OFS  = 16'h0CFC
) (
  input  logic        is_io,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic        idx_en,
  input  logic [7:0]  idx_bus,
  input  logic [4:0]  idx_dev,
  input  logic [2:0]  idx_func,
  input  logic [5:0]  idx_reg,
  output act_e        act,
  output cyc_t        cyc
);

  localparam int DEV_W = $clog2(SEL_N + 1);

  logic [1:0]       lane;
  logic [3:0]       be;
  logic             bad_size;
  logic             crosses;
  logic             win_hit;
  logic             io_low;
  logic             idx_hit;
  logic             dat_hit;
  logic [DEV_W-1:0] dev_scan;

  assign lane = addr[1:0];

  always_comb begin
    case (size)
      SZ_B1:   be = 4'b0001 << lane;
      SZ_B2:   be = 4'b0011 << lane;
      default: be = 4'b1111;
    endcase
  end

  assign bad_size = (size == SZ_BAD);
  assign crosses  = ({1'b0, lane} + size_bytes(size)) > 3'd4;

  assign win_hit = !is_io && (addr[31:WIN_AW] == WIN_BASE[31:WIN_AW]);
  assign io_low  = is_io && (addr[31:IO_AW] == '0);
  assign idx_hit = io_low && (addr[IO_AW-1:2] == IDX_OFS[IO_AW-1:2]);
  assign dat_hit = io_low && (addr[IO_AW-1:2] == DAT_OFS[IO_AW-1:2]);

  // Priority scan: the lowest set select bit wins; none set gives SEL_N.
  always_comb begin
    dev_scan = DEV_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (addr[SEL_LO + i]) dev_scan = DEV_W'(i);
    end
  end

  always_comb begin
    if (dev_scan < DEV_W'(SEL_N)) begin
      a_r3_scan_hit: assert (addr[SEL_LO + int'(dev_scan)]);
    end
  end

  always_comb begin
    act      = ACT_ERR;
    cyc.bus  = '0;
    cyc.dev  = 5'(dev_scan);
    cyc.func = addr[10:8];
    cyc.regn = addr[7:2];
    cyc.be   = be;
    cyc.lane = lane;
    if (bad_size || crosses) begin
      act = ACT_ERR;
    end else if (win_hit) begin
      act = ACT_CYCLE;
    end else if (idx_hit) begin
      act = (size == SZ_B4) ? ACT_INDEX : ACT_ERR;
    end else if (dat_hit) begin
      if (idx_en) begin
        act      = ACT_CYCLE;
        cyc.bus  = idx_bus;
        cyc.dev  = idx_dev;
        cyc.func = idx_func;
        cyc.regn = idx_reg;
      end else begin
        act = ACT_DUMMY;
      end
    end
  end

endmodule

// File: rtl/cfgx_index.sv
module cfgx_index #(
  parameter logic [31:0] KEEP_MASK = 32'h80FF_FFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] q
);

  logic [31:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
  import cfgx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    wr_lane,
  input  logic [DW-1:0] wr_in,
  output logic [DW-1:0] wr_out,
  input  logic [1:0]    rd_lane,
  input  logic [1:0]    rd_size,
  input  logic          rd_absent,
  input  logic [DW-1:0] rd_in,
  output logic [DW-1:0] rd_out
);

  localparam int SHW = $clog2(DW);

  logic [SHW-1:0] wr_sh;
  logic [SHW-1:0] rd_sh;
  logic [DW-1:0]  mask;

  assign wr_sh  = SHW'({wr_lane, 3'b000});
  assign rd_sh  = SHW'({rd_lane, 3'b000});
  assign mask   = DW'(size_mask(rd_size));
  assign wr_out = wr_in << wr_sh;
  assign rd_out = rd_absent ? mask : ((rd_in >> rd_sh) & mask);

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfgx_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_AW   = 22,
  parameter int          SEL_LO   = 11,
  parameter int          SEL_N    = 11,
  parameter int          IO_AW    = 16,
  parameter logic [15:0] IDX_OFS  = 16'h0CF8,
  parameter logic [15:0] DAT_OFS  = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req_valid,
  input  logic        cpu_io,
  input  logic [31:0] cpu_addr,
  input  logic [1:0]  cpu_size,
  input  logic        cpu_we,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        cpu_err,
  output logic        cfg_valid,
  output logic        cfg_we,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_reg,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_present
);

  st_e         st_q, st_d;
  act_e        act;
  cyc_t        cyc_dec, cyc_q;
  logic        we_q;
  logic [1:0]  size_q;
  logic [31:0] wdata_q;
  logic [31:0] wr_aligned;
  logic [31:0] rd_aligned;
  logic [31:0] idx_q;
  logic        idx_wr;
  logic        cyc_en;
  logic        resp_en;
  logic [31:0] rdata_d, rdata_q;
  logic        err_d, err_q;

  cfgx_decode #(
    .WIN_BASE (WIN_BASE),
    .WIN_AW   (WIN_AW),
    .SEL_LO   (SEL_LO),
    .SEL_N    (SEL_N),
    .IO_AW    (IO_AW),
    .IDX_OFS  (IDX_OFS),
    .DAT_OFS  (DAT_OFS)
  ) u_dec (
    .is_io    (cpu_io),
    .addr     (cpu_addr),
    .size     (cpu_size),
    .idx_en   (idx_q[31]),
    .idx_bus  (idx_q[23:16]),
    .idx_dev  (idx_q[15:11]),
    .idx_func (idx_q[10:8]),
    .idx_reg  (idx_q[7:2]),
    .act      (act),
    .cyc      (cyc_dec)
  );

  cfgx_index u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (idx_wr),
    .wr_data (cpu_wdata),
    .q       (idx_q)
  );

  cfgx_lane #(.DW(32)) u_lane (
    .wr_lane   (cpu_addr[1:0]),
    .wr_in     (cpu_wdata),
    .wr_out    (wr_aligned),
    .rd_lane   (cyc_q.lane),
    .rd_size   (size_q),
    .rd_absent (!cfg_present),
    .rd_in     (cfg_rdata),
    .rd_out    (rd_aligned)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cyc_en  = 1'b0;
    resp_en = 1'b0;
    idx_wr  = 1'b0;
    rdata_d = '0;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cpu_req_valid) begin
          case (act)
            ACT_CYCLE: begin
              st_d   = ST_CYC;
              cyc_en = 1'b1;
            end
            ACT_INDEX: begin
              st_d    = ST_RESP;
              resp_en = 1'b1;
              idx_wr  = cpu_we;
              rdata_d = cpu_we ? '0 : idx_q;
            end
            ACT_DUMMY: begin
              st_d    = ST_RESP;
              resp_en = 1'b1;
              rdata_d = cpu_we ? '0 : size_mask(cpu_size);
            end
            default: begin
              st_d    = ST_RESP;
              resp_en = 1'b1;
              err_d   = 1'b1;
            end
          endcase
        end
      end
      ST_CYC: begin
        if (cfg_ack) begin
          st_d    = ST_RESP;
          resp_en = 1'b1;
          rdata_d = we_q ? '0 : rd_aligned;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      we_q    <= 1'b0;
      size_q  <= SZ_B1;
      wdata_q <= '0;
    end else if (cyc_en) begin
      cyc_q   <= cyc_dec;
      we_q    <= cpu_we;
      size_q  <= cpu_size;
      wdata_q <= wr_aligned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (resp_en) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign cpu_ready = (st_q == ST_RESP);
  assign cpu_rdata = rdata_q;
  assign cpu_err   = err_q;
  assign cfg_valid = (st_q == ST_CYC);
  assign cfg_we    = we_q;
  assign cfg_bus   = cyc_q.bus;
  assign cfg_dev   = cyc_q.dev;
  assign cfg_func  = cyc_q.func;
  assign cfg_reg   = cyc_q.regn;
  assign cfg_be    = cyc_q.be;
  assign cfg_wdata = wdata_q;

  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ack |=> cfg_valid && $stable(cfg_dev) && $stable(cfg_reg)
      && $stable(cfg_func) && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_we));

  a_r11_ack_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ack |=> cpu_ready && !cfg_valid);

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                  4'b0011, 4'b0110, 4'b1100, 4'b1111}));

  a_r5_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_err |-> !$past(cfg_valid));

endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cpu_req_valid;
  logic        cpu_io;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic        cpu_we;
  logic [31:0] cpu_wdata;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        cpu_err;
  logic        cfg_valid;
  logic        cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack;
  logic [31:0] cfg_rdata;
  logic        cfg_present;

  int errors;
  int checks;
  int ack_delay;
  int wait_cnt;
  int cyc_count;
  logic [7:0]  last_bus;
  logic [4:0]  last_dev;
  logic [2:0]  last_func;
  logic [5:0]  last_reg;
  logic [3:0]  last_be;
  logic        last_we;
  logic [31:0] last_wdata;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  cfg_xlate dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_io        (cpu_io),
    .cpu_addr      (cpu_addr),
    .cpu_size      (cpu_size),
    .cpu_we        (cpu_we),
    .cpu_wdata     (cpu_wdata),
    .cpu_ready     (cpu_ready),
    .cpu_rdata     (cpu_rdata),
    .cpu_err       (cpu_err),
    .cfg_valid     (cfg_valid),
    .cfg_we        (cfg_we),
    .cfg_bus       (cfg_bus),
    .cfg_dev       (cfg_dev),
    .cfg_func      (cfg_func),
    .cfg_reg       (cfg_reg),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_ack       (cfg_ack),
    .cfg_rdata     (cfg_rdata),
    .cfg_present   (cfg_present)
  );

  // Responder model: answers with a pattern built from the target fields.
  assign cfg_rdata   = {cfg_bus, 3'b000, cfg_dev, 5'b00000, cfg_func, cfg_reg, 2'b00};
  assign cfg_present = (cfg_dev < 5'd9) || (cfg_dev == 5'd10);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ack   <= 1'b0;
      wait_cnt  <= 0;
      cyc_count <= 0;
    end else begin
      if (cfg_valid && cfg_ack) begin
        cyc_count  <= cyc_count + 1;
        last_bus   <= cfg_bus;
        last_dev   <= cfg_dev;
        last_func  <= cfg_func;
        last_reg   <= cfg_reg;
        last_be    <= cfg_be;
        last_we    <= cfg_we;
        last_wdata <= cfg_wdata;
      end
      if (cfg_valid && !cfg_ack) begin
        if (wait_cnt + 1 >= ack_delay) begin
          cfg_ack  <= 1'b1;
          wait_cnt <= 0;
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end else begin
        cfg_ack <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Issue one CPU access and return data, error flag and edge count to ready.
  task automatic access(input logic io, input logic [31:0] addr, input logic [1:0] sz,
                        input logic we, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err, output int lat);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_io        = io;
    cpu_addr      = addr;
    cpu_size      = sz;
    cpu_we        = we;
    cpu_wdata     = wd;
    lat = 0;
    for (int n = 0; n < 1000; n++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (cpu_ready) break;
    end
    if (!cpu_ready) begin
      errors++;
      $display("FAIL watchdog: no ready for addr 0x%08h", addr);
    end
    rd  = cpu_rdata;
    err = cpu_err;
    cpu_req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic e; int l;
    chk("R1 ready low", 32'(cpu_ready), 0);
    chk("R1 cfg_valid low", 32'(cfg_valid), 0);
    access(1'b1, 32'h0CF8, 2'd2, 1'b0, 0, rd, e, l);
    chk("R1 index reset value", rd, 32'h0);
    chk("R1 index read latency", 32'(l), 1);
  endtask

  task automatic t_direct_read();
    logic [31:0] rd; logic e; int l; int c0;
    c0 = cyc_count;
    access(1'b0, 32'h8080_2304, 2'd2, 1'b0, 0, rd, e, l);
    chk("R2 cycle started", 32'(cyc_count - c0), 1);
    chk("R2 bus zero", 32'(last_bus), 0);
    chk("R3 dev from bit 13", 32'(last_dev), 2);
    chk("R4 function", 32'(last_func), 3);
    chk("R4 register", 32'(last_reg), 1);
    chk("R5 be 4B", 32'(last_be), 32'hF);
    chk("R6 read data", rd, 32'h0002_0304);
    chk("R11 latency ack+2", 32'(l), 32'(ack_delay + 2));
  endtask

  task automatic t_scan();
    logic [31:0] rd; logic e; int l;
    access(1'b0, 32'h8088_4000, 2'd2, 1'b0, 0, rd, e, l);
    chk("R3 lowest of bits 14,19", 32'(last_dev), 3);
    access(1'b0, 32'h8080_0800, 2'd2, 1'b0, 0, rd, e, l);
    chk("R3 bit 11 is dev 0", 32'(last_dev), 0);
    access(1'b0, 32'h80A0_0000, 2'd2, 1'b0, 0, rd, e, l);
    chk("R3 bit 21 is dev 10", 32'(last_dev), 10);
    access(1'b0, 32'h8080_0000, 2'd2, 1'b0, 0, rd, e, l);
    chk("R3 no select is dev 11", 32'(last_dev), 11);
    chk("R7 absent 4B read", rd, 32'hFFFF_FFFF);
    access(1'b0, 32'h8080_0002, 2'd1, 1'b0, 0, rd, e, l);
    chk("R7 absent 2B read", rd, 32'h0000_FFFF);
  endtask

  task automatic t_lanes();
    logic [31:0] rd; logic e; int l;
    access(1'b0, 32'h8080_2302, 2'd0, 1'b0, 0, rd, e, l);
    chk("R5 be 1B lane2", 32'(last_be), 32'h4);
    chk("R6 1B lane2 read", rd, 32'h02);
    access(1'b0, 32'h8080_2301, 2'd1, 1'b0, 0, rd, e, l);
    chk("R5 be 2B lane1", 32'(last_be), 32'h6);
    chk("R6 2B lane1 read", rd, 32'h0203);
    access(1'b0, 32'h8080_2302, 2'd1, 1'b1, 32'h0000_ABCD, rd, e, l);
    chk("R6 write lane", last_wdata, 32'hABCD_0000);
    chk("R5 be 2B lane2", 32'(last_be), 32'hC);
    chk("R6 write flag", 32'(last_we), 1);
  endtask

  task automatic t_errors();
    logic [31:0] rd; logic e; int l; int c0;
    c0 = cyc_count;
    access(1'b0, 32'h8080_2303, 2'd1, 1'b0, 0, rd, e, l);
    chk("R5 crossing err", 32'(e), 1);
    chk("R5 crossing latency", 32'(l), 1);
    access(1'b0, 32'h8080_2300, 2'd3, 1'b0, 0, rd, e, l);
    chk("R5 size code 3 err", 32'(e), 1);
    access(1'b0, 32'h80C0_0000, 2'd2, 1'b0, 0, rd, e, l);
    chk("R2 outside window err", 32'(e), 1);
    access(1'b0, 32'h807F_FFFC, 2'd2, 1'b0, 0, rd, e, l);
    chk("R2 below window err", 32'(e), 1);
    access(1'b1, 32'h0CF0, 2'd2, 1'b0, 0, rd, e, l);
    chk("R12 other io err", 32'(e), 1);
    chk("R2 R5 R12 no cycles", 32'(cyc_count - c0), 0);
  endtask

  task automatic t_indirect();
    logic [31:0] rd; logic e; int l; int c0;
    access(1'b1, 32'h0CF8, 2'd2, 1'b1, 32'hFFFF_FFFF, rd, e, l);
    access(1'b1, 32'h0CF8, 2'd2, 1'b0, 0, rd, e, l);
    chk("R8 index keeps mask", rd, 32'h80FF_FFFC);
    access(1'b1, 32'h0CF8, 2'd1, 1'b0, 0, rd, e, l);
    chk("R8 index 2B err", 32'(e), 1);
    access(1'b1, 32'h0CF8, 2'd2, 1'b1, 32'h0000_1000, rd, e, l);
    c0 = cyc_count;
    access(1'b1, 32'h0CFE, 2'd0, 1'b0, 0, rd, e, l);
    chk("R10 disabled 1B read", rd, 32'hFF);
    chk("R10 disabled latency", 32'(l), 1);
    access(1'b1, 32'h0CFC, 2'd2, 1'b1, 32'h1234_5678, rd, e, l);
    chk("R10 disabled write dropped", 32'(cyc_count - c0), 0);
    access(1'b1, 32'h0CF8, 2'd2, 1'b1, 32'h8005_1A0C, rd, e, l);
    access(1'b1, 32'h0CFC, 2'd2, 1'b0, 0, rd, e, l);
    chk("R9 bus", 32'(last_bus), 5);
    chk("R9 dev", 32'(last_dev), 3);
    chk("R9 func", 32'(last_func), 2);
    chk("R9 reg", 32'(last_reg), 3);
    chk("R9 read data", rd, 32'h0503_020C);
    access(1'b1, 32'h0CFD, 2'd0, 1'b1, 32'h0000_005A, rd, e, l);
    chk("R9 write be", 32'(last_be), 32'h2);
    chk("R9 write data lane", last_wdata, 32'h0000_5A00);
  endtask

  task automatic t_slow_ack();
    logic [31:0] rd; logic e; int l;
    ack_delay = 4;
    access(1'b0, 32'h8080_1000, 2'd2, 1'b0, 0, rd, e, l);
    chk("R11 slow ack latency", 32'(l), 6);
    chk("R11 slow ack data", rd, 32'h0001_0000);
    ack_delay = 1;
  endtask

  initial begin
    errors = 0;
    checks = 0;
    ack_delay = 1;
    cpu_req_valid = 1'b0;
    cpu_io = 1'b0;
    cpu_addr = '0;
    cpu_size = 2'd0;
    cpu_we = 1'b0;
    cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_read();
    t_scan();
    t_lanes();
    t_errors();
    t_indirect();
    t_slow_ack();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule